// File: doc/BRIEF.md
# Scaled Add/Subtract and Compare Integer Unit

This block is the integer arithmetic execution stage of a 64-bit datapath. Each cycle it may accept one operation, given as a 7-bit function code, a 64-bit first operand and a second operand. The second operand is either a 64-bit register value or an 8-bit literal that is zero-extended. The result appears one clock later together with a valid strobe.

The operations are 32-bit (longword) and 64-bit (quadword) add and subtract. Both widths have forms that first multiply the first operand by 4 or by 8, and forms that raise an overflow trap flag. The unit also has five single-bit compares and a lane-wise byte compare that packs eight unsigned greater-or-equal tests into a mask. Longword results are sign-extended to 64 bits. A code the unit does not know raises an illegal flag and yields zero. Trap delivery, operand fetch and write-back belong to the surrounding pipeline.

Top module: `sxa_arith_unit`

## Requirements
- R1: When `op_valid` is high on a clock edge, `res_valid` is high after that edge. After any edge where `op_valid` was low or reset was asserted, `res_valid`, `res_data`, `res_ovf` and `res_illegal` are all zero.
- R2: With `use_lit` high, the second operand is `{56'b0, lit}` and `opb` is ignored. With `use_lit` low, the second operand is `opb`.
- R3: Code 0x20 yields A+B and code 0x29 yields A−B, both modulo 2^64.
- R4: Codes 0x00 (add) and 0x09 (subtract) compute on the low 32 bits. The 32-bit result is sign-extended to 64 bits.
- R5: The scaled codes use A·4 (A shifted left 2) or A·8 (A shifted left 3) in place of A. Longword: 0x02 = 4A+B, 0x12 = 8A+B, 0x0B = 4A−B, 0x1B = 8A−B, sign-extended as in R4. Quadword: 0x22 = 4A+B, 0x32 = 8A+B, 0x2B = 4A−B, 0x3B = 8A−B.
- R6: The trapping adds are 0x40 (longword, sign bit 31) and 0x60 (quadword, sign bit 63). `res_ovf` is high when A and B have equal sign bits and the result's sign bit differs from A's. The wrapped result is still delivered.
- R7: The trapping subtracts are 0x49 (longword) and 0x69 (quadword). `res_ovf` is high when A and B have different sign bits and the result's sign bit differs from A's. The wrapped result is still delivered.
- R8: `res_ovf` is never high for a code other than 0x40, 0x60, 0x49 or 0x69.
- R9: The compares write 1 or 0 in bit 0 and clear bits 63:1. The codes are 0x2D A==B, 0x6D signed A<=B, 0x4D signed A<B, 0x3D unsigned A<=B, 0x1D unsigned A<B.
- R10: Code 0x0F sets result bit i (i = 0..7) when byte lane i of A (bits 8i+7:8i) is unsigned-greater-or-equal to lane i of B. Bits 63:8 are zero.
- R11: Any other code gives `res_illegal` = 1, `res_data` = 0 and `res_ovf` = 0. Every listed code gives `res_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| func | input | 7 | Function code |
| opa | input | 64 | First operand A |
| opb | input | 64 | Register second operand |
| lit | input | 8 | Literal second operand |
| use_lit | input | 1 | Select literal as second operand |
| res_valid | output | 1 | Result strobe, one cycle after op_valid |
| res_data | output | 64 | Result |
| res_ovf | output | 1 | Integer overflow trap flag |
| res_illegal | output | 1 | Unrecognised function code |

## Verification
Add and subtract run on operands whose low-half carry crosses bit 31. This separates longword sign extension from a plain 64-bit result. The scaled forms use operands whose high bits fall off on the shift, so a wrong shift amount or a scale of the wrong operand shows up. The trapping forms see both overflow edges, MAX+1 and MIN−1, and the same operands under the non-trapping codes. Mixed-sign pairs must not flag, which tells the add rule from the subtract rule. Compares use −1 against 1, so signed and unsigned orders disagree, and equal operands, so <= differs from <. The byte compare gets lanes that are above, equal and below so that each mask bit is checked on its own. The literal path carries a register value that would change the answer if it leaked through.

// File: rtl/sxa_pkg.sv
// Package: shared function codes and decoded-operation type for the
// scaled add/subtract/compare unit. Assumes a 7-bit function field.
package sxa_pkg;

    localparam int FUNC_W = 7;

    // Add family
    localparam logic [FUNC_W-1:0] F_ADDL   = 7'h00;
    localparam logic [FUNC_W-1:0] F_ADDLT  = 7'h40;
    localparam logic [FUNC_W-1:0] F_S4ADDL = 7'h02;
    localparam logic [FUNC_W-1:0] F_S8ADDL = 7'h12;
    localparam logic [FUNC_W-1:0] F_ADDQ   = 7'h20;
    localparam logic [FUNC_W-1:0] F_ADDQT  = 7'h60;
    localparam logic [FUNC_W-1:0] F_S4ADDQ = 7'h22;
    localparam logic [FUNC_W-1:0] F_S8ADDQ = 7'h32;
    // Subtract family
    localparam logic [FUNC_W-1:0] F_SUBL   = 7'h09;
    localparam logic [FUNC_W-1:0] F_SUBLT  = 7'h49;
    localparam logic [FUNC_W-1:0] F_S4SUBL = 7'h0B;
    localparam logic [FUNC_W-1:0] F_S8SUBL = 7'h1B;
    localparam logic [FUNC_W-1:0] F_SUBQ   = 7'h29;
    localparam logic [FUNC_W-1:0] F_SUBQT  = 7'h69;
    localparam logic [FUNC_W-1:0] F_S4SUBQ = 7'h2B;
    localparam logic [FUNC_W-1:0] F_S8SUBQ = 7'h3B;
    // Compares
    localparam logic [FUNC_W-1:0] F_CEQ    = 7'h2D;
    localparam logic [FUNC_W-1:0] F_CSLE   = 7'h6D;
    localparam logic [FUNC_W-1:0] F_CSLT   = 7'h4D;
    localparam logic [FUNC_W-1:0] F_CULE   = 7'h3D;
    localparam logic [FUNC_W-1:0] F_CULT   = 7'h1D;
    localparam logic [FUNC_W-1:0] F_BYTGE  = 7'h0F;

    typedef enum logic [2:0] {
        K_ADD = 3'd0,
        K_SUB = 3'd1,
        K_CMP = 3'd2,
        K_BGE = 3'd3,
        K_ILL = 3'd4
    } op_kind_e;

    typedef enum logic [2:0] {
        C_EQ  = 3'd0,
        C_SLE = 3'd1,
        C_SLT = 3'd2,
        C_ULE = 3'd3,
        C_ULT = 3'd4
    } cmp_sel_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       is_long;
        logic [1:0] shamt;
        logic       trap;
        cmp_sel_e   cmp;
    } dec_op_t;

endpackage

// File: rtl/sxa_decode.sv
// Module: sxa_decode
// Maps a function code to a decoded operation. Purely combinational.
// Assumes the code is stable while op_valid is high; unknown codes
// decode to K_ILL.
module sxa_decode
    import sxa_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    output dec_op_t           dec
);

    // Decode table: one entry per supported code
    always_comb begin
        dec         = '0;
        dec.kind    = K_ILL;
        dec.cmp     = C_EQ;
        unique case (func)
            F_ADDL:   begin dec.kind = K_ADD; dec.is_long = 1'b1; end
            F_ADDLT:  begin dec.kind = K_ADD; dec.is_long = 1'b1; dec.trap = 1'b1; end
            F_S4ADDL: begin dec.kind = K_ADD; dec.is_long = 1'b1; dec.shamt = 2'd2; end
            F_S8ADDL: begin dec.kind = K_ADD; dec.is_long = 1'b1; dec.shamt = 2'd3; end
            F_ADDQ:   begin dec.kind = K_ADD; end
            F_ADDQT:  begin dec.kind = K_ADD; dec.trap = 1'b1; end
            F_S4ADDQ: begin dec.kind = K_ADD; dec.shamt = 2'd2; end
            F_S8ADDQ: begin dec.kind = K_ADD; dec.shamt = 2'd3; end
            F_SUBL:   begin dec.kind = K_SUB; dec.is_long = 1'b1; end
            F_SUBLT:  begin dec.kind = K_SUB; dec.is_long = 1'b1; dec.trap = 1'b1; end
            F_S4SUBL: begin dec.kind = K_SUB; dec.is_long = 1'b1; dec.shamt = 2'd2; end
            F_S8SUBL: begin dec.kind = K_SUB; dec.is_long = 1'b1; dec.shamt = 2'd3; end
            F_SUBQ:   begin dec.kind = K_SUB; end
            F_SUBQT:  begin dec.kind = K_SUB; dec.trap = 1'b1; end
            F_S4SUBQ: begin dec.kind = K_SUB; dec.shamt = 2'd2; end
            F_S8SUBQ: begin dec.kind = K_SUB; dec.shamt = 2'd3; end
            F_CEQ:    begin dec.kind = K_CMP; dec.cmp = C_EQ;  end
            F_CSLE:   begin dec.kind = K_CMP; dec.cmp = C_SLE; end
            F_CSLT:   begin dec.kind = K_CMP; dec.cmp = C_SLT; end
            F_CULE:   begin dec.kind = K_CMP; dec.cmp = C_ULE; end
            F_CULT:   begin dec.kind = K_CMP; dec.cmp = C_ULT; end
            F_BYTGE:  begin dec.kind = K_BGE; end
            default:  begin dec.kind = K_ILL; end
        endcase
    end

endmodule

// File: rtl/sxa_addsub.sv
// Module: sxa_addsub
// Scaled add/subtract with optional longword sign extension and overflow
// detection. Combinational. Assumes shamt is 0, 2 or 3, and that trap is
// only set for unscaled forms (the overflow rule uses the scaled A).
module sxa_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    input  logic              is_long,
    input  logic [1:0]        shamt,
    input  logic              trap,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] raw;
    logic              sa, sb, sr;

    // Scale A by a left shift before the operation
    always_comb a_sc = a << shamt;

    // Single adder: subtract uses inverted B with carry in
    always_comb raw = a_sc + (is_sub ? ~b : b) + {{(DATA_W-1){1'b0}}, is_sub};

    // Longword results are sign-extended from the low half
    always_comb res = is_long ? {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]} : raw;

    // Pick sign bits at the operating width
    always_comb begin
        sa = is_long ? a_sc[HALF_W-1] : a_sc[DATA_W-1];
        sb = is_long ? b[HALF_W-1]    : b[DATA_W-1];
        sr = is_long ? raw[HALF_W-1]  : raw[DATA_W-1];
    end

    // Overflow: add needs equal signs, subtract needs different signs
    always_comb ovf = trap && (sr != sa) && (is_sub ? (sa != sb) : (sa == sb));

endmodule

// File: rtl/sxa_compare.sv
// Module: sxa_compare
// Single-bit compares and the lane-wise unsigned byte compare.
// Combinational. Assumes DATA_W is a multiple of LANE_W and that the
// lane count fits in DATA_W result bits.
module sxa_compare
    import sxa_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  cmp_sel_e          sel,
    output logic [DATA_W-1:0] cmp_res,
    output logic [DATA_W-1:0] bge_res
);

    localparam int LANES = DATA_W / LANE_W;

    logic             bit_res;
    logic [LANES-1:0] lane_ge;

    // Select one of the five scalar relations
    always_comb begin
        unique case (sel)
            C_EQ:    bit_res = (a == b);
            C_SLE:   bit_res = ($signed(a) <= $signed(b));
            C_SLT:   bit_res = ($signed(a) <  $signed(b));
            C_ULE:   bit_res = (a <= b);
            C_ULT:   bit_res = (a <  b);
            default: bit_res = 1'b0;
        endcase
    end

    // Zero-extend the scalar relation
    always_comb cmp_res = {{(DATA_W-1){1'b0}}, bit_res};

    // One unsigned >= comparator per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ge[g] = a[g*LANE_W +: LANE_W] >= b[g*LANE_W +: LANE_W];
    end

    // Pack lane results into the low bits
    always_comb bge_res = {{(DATA_W-LANES){1'b0}}, lane_ge};

endmodule

// File: rtl/sxa_arith_unit.sv
// Module: sxa_arith_unit (top)
// Integer arithmetic execution stage: decodes a function code, selects
// the second operand (register or zero-extended literal), computes the
// result and registers it with a valid strobe one cycle later.
// Assumes a synchronous active-low reset; outputs are zero when idle.
module sxa_arith_unit
    import sxa_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [6:0]        func,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [LIT_W-1:0]  lit,
    input  logic              use_lit,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_ovf,
    output logic              res_illegal
);

    dec_op_t           dec;
    logic [DATA_W-1:0] b_op;
    logic [DATA_W-1:0] as_res, cmp_res, bge_res;
    logic              as_ovf;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_ovf, nxt_ill;

    sxa_decode u_dec (
        .func (func),
        .dec  (dec)
    );

    // Second operand: register or zero-extended literal
    always_comb b_op = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : opb;

    sxa_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (opa),
        .b       (b_op),
        .is_sub  (dec.kind == K_SUB),
        .is_long (dec.is_long),
        .shamt   (dec.shamt),
        .trap    (dec.trap),
        .res     (as_res),
        .ovf     (as_ovf)
    );

    sxa_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .a       (opa),
        .b       (b_op),
        .sel     (dec.cmp),
        .cmp_res (cmp_res),
        .bge_res (bge_res)
    );

    // Result mux by operation kind
    always_comb begin
        nxt_data = '0;
        nxt_ovf  = 1'b0;
        nxt_ill  = 1'b0;
        unique case (dec.kind)
            K_ADD, K_SUB: begin nxt_data = as_res; nxt_ovf = as_ovf; end
            K_CMP:        nxt_data = cmp_res;
            K_BGE:        nxt_data = bge_res;
            default:      nxt_ill  = 1'b1;
        endcase
    end

    // Output register: capture on valid, clear when idle or in reset
    always_ff @(posedge clk) begin
        if (!rst_n || !op_valid) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_ovf     <= 1'b0;
            res_illegal <= 1'b0;
        end else begin
            res_valid   <= 1'b1;
            res_data    <= nxt_data;
            res_ovf     <= nxt_ovf;
            res_illegal <= nxt_ill;
        end
    end

endmodule

// File: rtl/sxa_arith_chk.sv
// Module: sxa_arith_chk
// Property checker bound to sxa_arith_unit. Observes ports only.
module sxa_arith_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [6:0]  func,
    input logic        res_valid,
    input logic [63:0] res_data,
    input logic        res_ovf,
    input logic        res_illegal
);

    logic is_trap_code, is_cmp_code, is_long_code;

    // Classify the incoming code from its listed values
    always_comb begin
        is_trap_code = (func == 7'h40) || (func == 7'h60) || (func == 7'h49) || (func == 7'h69);
        is_cmp_code  = (func == 7'h2D) || (func == 7'h6D) || (func == 7'h4D) ||
                       (func == 7'h3D) || (func == 7'h1D);
        is_long_code = (func == 7'h00) || (func == 7'h40) || (func == 7'h02) || (func == 7'h12) ||
                       (func == 7'h09) || (func == 7'h49) || (func == 7'h0B) || (func == 7'h1B);
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && res_data == 64'd0 && !res_ovf && !res_illegal));
    p_long_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_long_code) |=> (res_data[63:32] == {32{res_data[31]}}));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_trap_code) |=> !res_ovf);
    p_cmp_onebit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_cmp_code) |=> (res_data[63:1] == 63'd0));
    p_bytemask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func == 7'h0F) |=> (res_data[63:8] == 56'd0));
    p_illegal_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (res_data == 64'd0 && !res_ovf && res_valid));

endmodule

bind sxa_arith_unit sxa_arith_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .func        (func),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_ovf     (res_ovf),
    .res_illegal (res_illegal)
);

// File: tb/sxa_arith_unit_tb.sv
module sxa_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0, opb = '0;
    logic [7:0]  lit = '0;
    logic        use_lit = 1'b0;
    logic        res_valid, res_ovf, res_illegal;
    logic [63:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] q_res[$];
    logic        q_ovf[$];
    logic        q_ill[$];
    string       q_tag[$];

    always #2 clk = ~clk;   // 250 MHz

    sxa_arith_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .func(func),
        .opa(opa), .opb(opb), .lit(lit), .use_lit(use_lit),
        .res_valid(res_valid), .res_data(res_data),
        .res_ovf(res_ovf), .res_illegal(res_illegal)
    );

    // Reference model written from the requirements
    function automatic void model(input logic [6:0] f, input logic [63:0] a,
                                  input logic [63:0] b, output logic [63:0] r,
                                  output logic o, output logic il);
        logic [63:0] as;
        logic [63:0] t;
        logic        lng, sub, trp, arith;
        int          sh;
        r = '0; o = 1'b0; il = 1'b0; lng = 1'b0; sub = 1'b0; trp = 1'b0; arith = 1'b1; sh = 0;
        case (f)
            7'h00: lng = 1;              7'h40: begin lng = 1; trp = 1; end
            7'h02: begin lng = 1; sh = 2; end  7'h12: begin lng = 1; sh = 3; end
            7'h20: ;                     7'h60: trp = 1;
            7'h22: sh = 2;               7'h32: sh = 3;
            7'h09: begin lng = 1; sub = 1; end 7'h49: begin lng = 1; sub = 1; trp = 1; end
            7'h0B: begin lng = 1; sub = 1; sh = 2; end 7'h1B: begin lng = 1; sub = 1; sh = 3; end
            7'h29: sub = 1;              7'h69: begin sub = 1; trp = 1; end
            7'h2B: begin sub = 1; sh = 2; end  7'h3B: begin sub = 1; sh = 3; end
            default: arith = 0;
        endcase
        if (arith) begin
            as = a << sh;
            t  = sub ? as - b : as + b;
            if (lng) begin
                r = {{32{t[31]}}, t[31:0]};
                if (trp) o = sub ? (as[31] != b[31] && t[31] != as[31])
                                 : (as[31] == b[31] && t[31] != as[31]);
            end else begin
                r = t;
                if (trp) o = sub ? (as[63] != b[63] && t[63] != as[63])
                                 : (as[63] == b[63] && t[63] != as[63]);
            end
        end else begin
            case (f)
                7'h2D: r = {63'd0, a == b};
                7'h6D: r = {63'd0, $signed(a) <= $signed(b)};
                7'h4D: r = {63'd0, $signed(a) <  $signed(b)};
                7'h3D: r = {63'd0, a <= b};
                7'h1D: r = {63'd0, a <  b};
                7'h0F: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
                default: il = 1'b1;
            endcase
        end
    endfunction

    // Driver: apply one operation and push its expectation
    task automatic drive(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         input logic [7:0] l, input logic ul, input string tag);
        logic [63:0] r; logic o, il;
        @(negedge clk);
        func = f; opa = a; opb = b; lit = l; use_lit = ul; op_valid = 1'b1;
        model(f, a, ul ? {56'd0, l} : b, r, o, il);
        q_res.push_back(r); q_ovf.push_back(o); q_ill.push_back(il); q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        op_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pop expectations as results emerge
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (q_res.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected result %h exp none", res_data);
            end else begin
                logic [63:0] er; logic eo, ei; string tg;
                er = q_res.pop_front(); eo = q_ovf.pop_front();
                ei = q_ill.pop_front(); tg = q_tag.pop_front();
                if (res_data !== er || res_ovf !== eo || res_illegal !== ei) begin
                    fails++;
                    $display("FAIL %s act=%h/%b/%b exp=%h/%b/%b", tg,
                             res_data, res_ovf, res_illegal, er, eo, ei);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check_idle(input string tag);
        checks++;
        if (res_valid !== 1'b0 || res_data !== 64'd0 || res_ovf !== 1'b0 || res_illegal !== 1'b0) begin
            fails++;
            $display("FAIL %s idle act=%b/%h/%b/%b exp=0/0/0/0", tag,
                     res_valid, res_data, res_ovf, res_illegal);
        end
    endtask

    initial begin
        // R1: reset holds outputs at zero even with op_valid high
        op_valid = 1'b1; func = 7'h20; opa = 64'd5; opb = 64'd6;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R3 quad add/sub
        drive(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 8'd0, 0, "R3 addq wrap");
        drive(7'h29, 64'd3, 64'd5, 8'd0, 0, "R3 subq borrow");
        drive(7'h20, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0, 0, "R3 addq no sext");
        // R4 longword
        drive(7'h00, 64'h1234_5678_7FFF_FFFF, 64'd1, 8'd0, 0, "R4 addl sext");
        drive(7'h09, 64'h0, 64'd1, 8'd0, 0, "R4 subl neg");
        drive(7'h00, 64'hFFFF_FFFF_0000_0001, 64'hAAAA_AAAA_0000_0002, 8'd0, 0, "R4 addl high ignored");
        // R5 scaled
        drive(7'h02, 64'h0000_0000_4000_0001, 64'd1, 8'd0, 0, "R5 s4addl");
        drive(7'h12, 64'h0000_0000_1000_0003, 64'd2, 8'd0, 0, "R5 s8addl");
        drive(7'h0B, 64'd1, 64'd5, 8'd0, 0, "R5 s4subl");
        drive(7'h1B, 64'd2, 64'd3, 8'd0, 0, "R5 s8subl");
        drive(7'h22, 64'hC000_0000_0000_0001, 64'd7, 8'd0, 0, "R5 s4addq");
        drive(7'h32, 64'h2000_0000_0000_0005, 64'd1, 8'd0, 0, "R5 s8addq");
        drive(7'h2B, 64'd10, 64'd41, 8'd0, 0, "R5 s4subq");
        drive(7'h3B, 64'd10, 64'd79, 8'd0, 0, "R5 s8subq");
        // R6 trapping add
        drive(7'h40, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0, 0, "R6 addl ovf");
        drive(7'h40, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 8'd0, 0, "R6 addl neg ovf");
        drive(7'h40, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 8'd0, 0, "R6 addl mixed no ovf");
        drive(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, "R6 addq ovf");
        drive(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 0, "R6 addq no ovf");
        // R7 trapping sub
        drive(7'h49, 64'h0000_0000_8000_0000, 64'd1, 8'd0, 0, "R7 subl ovf");
        drive(7'h49, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 8'd0, 0, "R7 subl same sign");
        drive(7'h69, 64'h8000_0000_0000_0000, 64'd1, 8'd0, 0, "R7 subq ovf");
        drive(7'h69, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 0, "R7 subq ovf pos");
        drive(7'h69, 64'd5, 64'd9, 8'd0, 0, "R7 subq no ovf");
        // R8 non-trapping with overflowing operands
        drive(7'h00, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0, 0, "R8 addl");
        drive(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, "R8 addq");
        drive(7'h29, 64'h8000_0000_0000_0000, 64'd1, 8'd0, 0, "R8 subq");
        // R9 compares
        drive(7'h2D, 64'd9, 64'd9, 8'd0, 0, "R9 eq true");
        drive(7'h2D, 64'd9, 64'h1_0000_0009, 8'd0, 0, "R9 eq false");
        drive(7'h4D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, "R9 slt -1<1");
        drive(7'h1D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, "R9 ult -1<1");
        drive(7'h6D, 64'd4, 64'd4, 8'd0, 0, "R9 sle equal");
        drive(7'h4D, 64'd4, 64'd4, 8'd0, 0, "R9 slt equal");
        drive(7'h3D, 64'd4, 64'd4, 8'd0, 0, "R9 ule equal");
        drive(7'h1D, 64'd4, 64'd4, 8'd0, 0, "R9 ult equal");
        drive(7'h6D, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 0, "R9 sle 1<=-1");
        drive(7'h3D, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 0, "R9 ule 1<=-1");
        // R10 byte compare
        drive(7'h0F, 64'h00FF_1080_7F01_0000, 64'h0100_1080_8000_FF00, 8'd0, 0, "R10 mixed lanes");
        drive(7'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd0, 0, "R10 all ge");
        drive(7'h0F, 64'h0, 64'h0101_0101_0101_0101, 8'd0, 0, "R10 none ge");
        // R2 literal path
        drive(7'h20, 64'd100, 64'hDEAD_BEEF_0000_0000, 8'hFF, 1, "R2 lit add");
        drive(7'h29, 64'd0, 64'd1, 8'h80, 1, "R2 lit sub");
        drive(7'h2D, 64'd7, 64'h0, 8'h07, 1, "R2 lit eq");
        drive(7'h0F, 64'h0000_0000_0000_0010, 64'hFFFF_FFFF_FFFF_FFFF, 8'h10, 1, "R2 lit bytecmp");
        // R11 illegal
        drive(7'h01, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 0, "R11 code 01");
        drive(7'h7F, 64'd1, 64'd1, 8'd0, 0, "R11 code 7F");
        drive(7'h61, 64'h8000_0000_0000_0000, 64'd1, 8'd0, 0, "R11 code 61");
        idle(3);
        check_idle("R1 idle after burst");

        // Back-to-back mix then gap then resume
        for (int k = 0; k < 16; k++) begin
            drive(k[0] ? 7'h2B : 7'h12, 64'h0123_4567_89AB_CDEF * (k + 1),
                  64'hFEDC_BA98_7654_3210 ^ k, 8'd0, 0, "R5 stream");
        end
        idle(3);
        check_idle("R1 idle final");

        repeat (2) @(negedge clk);
        checks++;
        if (q_res.size() != 0) begin
            fails++;
            $display("FAIL R1 missing results act=%0d exp=0", q_res.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule